// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels is served next. Each channel can raise a request in two ways. One is a hardware request pin, whose active level software chooses. The other is a software request bit. A per-channel mask blocks the hardware pin, and a per-channel mode records whether software requests are accepted. Among the requests that survive, one channel is picked by fixed or rotating priority and handed to the transfer sequencer. The block drives that channel's acknowledge pin at a level software also chooses.

The CPU side writes registers through one-cycle decoded strobes, each paired with the shared byte `wrData`. The sequencer reports three things: when it is idle, when it has finished with the current grant, and per-channel terminal-count and end-of-process events. Those events clear software requests, can mask the channel automatically, and latch completion flags into a status byte. Reading that byte clears the flags.

Top module: `dmaarb_top`

## Requirements
- R1: With command bit 4 clear, the lowest-numbered pending channel wins (channel 0 highest, channel 3 lowest).
- R2: With command bit 4 set, the search starts one above the most recently granted channel and wraps, so the last channel served has the lowest priority. After reset or master clear the search starts at channel 0.
- R3: A grant is taken only on an edge where `seqIdle` is high and no grant is held. `grantValid` and `grantIdx` appear one cycle after the deciding edge. They stay unchanged, even when new requests arrive, until `seqRelease` is sampled high, and `grantValid` falls on that edge.
- R4: While command bit 2 is set, no new grant is issued.
- R5: Command bit 6 set makes the request pins active low; clear makes them active high. Command bit 7 set makes acknowledge active high; clear makes it active low. Only the granted channel's acknowledge pin is at its active level, and no pin is active without a grant.
- R6: A masked channel's request pin is ignored. The single-mask write uses `wrData[1:0]` for the channel and `wrData[2]` for set (1) or clear (0). The all-mask write loads `wrData[3:0]`. The clear-mask strobe zeroes all four masks.
- R7: The request write uses `wrData[1:0]` for the channel and `wrData[2]` to set or clear its software request. A software request ignores the mask but counts only when the channel's mode field `wrData[7:6]` equals 2'b10 (block). The mode write selects its channel with `wrData[1:0]` and sets auto-initialise with `wrData[4]`.
- R8: A terminal-count or end-of-process event on a channel clears its software request. It also sets its mask unless that channel has auto-initialise. Such an event takes precedence over a CPU write in the same cycle.
- R9: Status bits 3:0 flag a terminal-count or end-of-process event per channel. Bits 7:4 show, per channel, an active request pin or a set software request bit, regardless of mask and mode. A `statusRd` strobe clears bits 3:0 on its edge, but an event on the same edge still sets its flag.
- R10: Reset and the master-clear strobe clear the command byte, software requests and status flags, set all four masks, drop any grant and restart rotation at channel 0. Master clear leaves channel modes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 8 | Data carried by the register write strobes |
| cmdWr | input | 1 | Load command byte |
| modeWr | input | 1 | Load one channel's mode |
| reqWr | input | 1 | Set or clear one software request |
| maskOneWr | input | 1 | Set or clear one mask bit |
| maskAllWr | input | 1 | Load all mask bits |
| maskClrWr | input | 1 | Clear all mask bits |
| masterClr | input | 1 | Software equivalent of reset |
| statusRd | input | 1 | Status read strobe, clears completion flags |
| dreqPin | input | 4 | Hardware request pins, polarity per command bit 6 |
| tcEvt | input | 4 | Per-channel terminal-count pulse from the sequencer |
| eopEvt | input | 4 | Per-channel end-of-process pulse from the sequencer |
| seqIdle | input | 1 | Sequencer can accept a new grant |
| seqRelease | input | 1 | Sequencer finished with the current grant |
| grantIdx | output | 2 | Granted channel |
| grantValid | output | 1 | A grant is held |
| dackPin | output | 4 | Acknowledge pins, polarity per command bit 7 |
| statusOut | output | 8 | Status byte |

## Verification
The bench steps a rotating-priority sequence in which each expected winner depends on the previous grant. A pointer that is never updated, or that is updated only in rotating mode, yields a wrong channel in that sequence. It raises a higher-priority request while a grant is held: an arbiter that re-decides every cycle would switch channels. It also raises requests while the sequencer is busy, and one that ignores `seqIdle` would grant early. End events are applied to channels with and without auto-initialise, and a status read lands on the same edge as a new event. A wrong mask update shows up as a missing or an extra re-grant, and a wrong clear priority shows up as a lost flag. Masked hardware requests are checked against unmasked software requests, and a block-mode software request is checked against a single-mode one.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;

  // command byte fields
  localparam int CMD_OFF     = 2;
  localparam int CMD_ROT     = 4;
  localparam int CMD_REQLOW  = 6;
  localparam int CMD_ACKHIGH = 7;

  // mode byte fields
  localparam int MODE_AUTO = 4;
  localparam logic [1:0] MODE_BLOCK = 2'b10;

  // register update strobes handed from control to datapath
  typedef struct packed {
    logic cmdLoad;
    logic modeLoad;
    logic reqLoad;
    logic maskOneLoad;
    logic maskAllLoad;
    logic maskClear;
    logic flagClear;
    logic wipe;
  } regStrobe_t;

endpackage

// File: rtl/dmaarb_prio.sv
module dmaarb_prio #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CH_W-1:0]   base,
  output logic              hit,
  output logic [CH_W-1:0]   win
);

  int slot;

  // scan channels starting at base, wrapping around
  always_comb begin
    hit  = 1'b0;
    win  = '0;
    slot = 0;
    for (int k = 0; k < NUM_CH; k++) begin
      slot = (int'(base) + k) % NUM_CH;
      if (!hit && req[slot]) begin
        hit = 1'b1;
        win = CH_W'(slot);
      end
    end
  end

endmodule

// File: rtl/dmaarb_regs.sv
module dmaarb_regs
  import dmaarb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          stb,
  input  logic [7:0]          wrData,
  input  logic [NUM_CH-1:0]   dreqPin,
  input  logic [NUM_CH-1:0]   tcEvt,
  input  logic [NUM_CH-1:0]   eopEvt,
  output logic [7:0]          cmdReg,
  output logic [NUM_CH-1:0]   maskReg,
  output logic [NUM_CH-1:0]   pending,
  output logic [2*NUM_CH-1:0] statusOut
);

  logic [NUM_CH-1:0] maskQ, maskD;
  logic [NUM_CH-1:0] reqQ, reqD;
  logic [NUM_CH-1:0] flagQ, flagD;
  logic [NUM_CH-1:0] blockQ, autoQ;
  logic [NUM_CH-1:0] endEvt, dreqAct;
  logic [7:0]        cmdQ;
  logic [CH_W-1:0]   selCh;
  logic              setBit;

  assign selCh   = wrData[CH_W-1:0];
  assign setBit  = wrData[CH_W];
  assign endEvt  = tcEvt | eopEvt;
  assign dreqAct = dreqPin ^ {NUM_CH{cmdQ[CMD_REQLOW]}};

  // mask next state: CPU writes, then automatic set at end, wipe last
  always_comb begin
    maskD = maskQ;
    if (stb.maskClear)   maskD = '0;
    if (stb.maskAllLoad) maskD = wrData[NUM_CH-1:0];
    if (stb.maskOneLoad) maskD[selCh] = setBit;
    maskD = maskD | (endEvt & ~autoQ);
    if (stb.wipe)        maskD = '1;
  end

  // software request next state: an end event beats a write
  always_comb begin
    reqD = reqQ;
    if (stb.reqLoad) reqD[selCh] = setBit;
    reqD = reqD & ~endEvt;
    if (stb.wipe)    reqD = '0;
  end

  // completion flags: read clears, same-edge event still sets
  always_comb begin
    flagD = stb.flagClear ? '0 : flagQ;
    flagD = flagD | endEvt;
    if (stb.wipe) flagD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= '0;
      maskQ <= '1;
      reqQ  <= '0;
      flagQ <= '0;
    end else begin
      maskQ <= maskD;
      reqQ  <= reqD;
      flagQ <= flagD;
      if (stb.wipe)         cmdQ <= '0;
      else if (stb.cmdLoad) cmdQ <= wrData;
    end
  end

  // per-channel mode bits, untouched by master clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockQ <= '0;
      autoQ  <= '0;
    end else if (stb.modeLoad) begin
      blockQ[selCh] <= (wrData[7:6] == MODE_BLOCK);
      autoQ[selCh]  <= wrData[MODE_AUTO];
    end
  end

  assign pending   = (dreqAct & ~maskQ) | (reqQ & blockQ);
  assign statusOut = {dreqAct | reqQ, flagQ};
  assign cmdReg    = cmdQ;
  assign maskReg   = maskQ;

endmodule

// File: rtl/dmaarb_ctrl.sv
module dmaarb_ctrl
  import dmaarb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic              modeWr,
  input  logic              reqWr,
  input  logic              maskOneWr,
  input  logic              maskAllWr,
  input  logic              maskClrWr,
  input  logic              masterClr,
  input  logic              statusRd,
  input  logic              seqIdle,
  input  logic              seqRelease,
  input  logic [NUM_CH-1:0] pending,
  input  logic              ctrlOff,
  input  logic              rotate,
  output regStrobe_t        stb,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantIdx
);

  localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] lastPtr, rotBase, winCh;
  logic            anyHit, takeGrant;

  always_comb begin
    stb             = '0;
    stb.cmdLoad     = cmdWr;
    stb.modeLoad    = modeWr;
    stb.reqLoad     = reqWr;
    stb.maskOneLoad = maskOneWr;
    stb.maskAllLoad = maskAllWr;
    stb.maskClear   = maskClrWr;
    stb.flagClear   = statusRd;
    stb.wipe        = masterClr;
  end

  always_comb begin
    if (!rotate)               rotBase = '0;
    else if (lastPtr == TOP_CH) rotBase = '0;
    else                        rotBase = lastPtr + CH_W'(1);
  end

  dmaarb_prio #(.NUM_CH(NUM_CH)) u_prio (
    .req  (pending),
    .base (rotBase),
    .hit  (anyHit),
    .win  (winCh)
  );

  assign takeGrant = seqIdle && !grantValid && !ctrlOff && anyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantIdx   <= '0;
      lastPtr    <= TOP_CH;
    end else if (masterClr) begin
      grantValid <= 1'b0;
      lastPtr    <= TOP_CH;
    end else if (takeGrant) begin
      grantValid <= 1'b1;
      grantIdx   <= winCh;
      lastPtr    <= winCh;
    end else if (grantValid && seqRelease) begin
      grantValid <= 1'b0;
    end
  end

endmodule

// File: rtl/dmaarb_top.sv
module dmaarb_top
  import dmaarb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          wrData,
  input  logic                cmdWr,
  input  logic                modeWr,
  input  logic                reqWr,
  input  logic                maskOneWr,
  input  logic                maskAllWr,
  input  logic                maskClrWr,
  input  logic                masterClr,
  input  logic                statusRd,
  input  logic [NUM_CH-1:0]   dreqPin,
  input  logic [NUM_CH-1:0]   tcEvt,
  input  logic [NUM_CH-1:0]   eopEvt,
  input  logic                seqIdle,
  input  logic                seqRelease,
  output logic [CH_W-1:0]     grantIdx,
  output logic                grantValid,
  output logic [NUM_CH-1:0]   dackPin,
  output logic [2*NUM_CH-1:0] statusOut
);

  regStrobe_t        stb;
  logic [7:0]        cmdReg;
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] pending;

  dmaarb_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWr      (cmdWr),
    .modeWr     (modeWr),
    .reqWr      (reqWr),
    .maskOneWr  (maskOneWr),
    .maskAllWr  (maskAllWr),
    .maskClrWr  (maskClrWr),
    .masterClr  (masterClr),
    .statusRd   (statusRd),
    .seqIdle    (seqIdle),
    .seqRelease (seqRelease),
    .pending    (pending),
    .ctrlOff    (cmdReg[CMD_OFF]),
    .rotate     (cmdReg[CMD_ROT]),
    .stb        (stb),
    .grantValid (grantValid),
    .grantIdx   (grantIdx)
  );

  dmaarb_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .dreqPin   (dreqPin),
    .tcEvt     (tcEvt),
    .eopEvt    (eopEvt),
    .cmdReg    (cmdReg),
    .maskReg   (maskReg),
    .pending   (pending),
    .statusOut (statusOut)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ack
    assign dackPin[i] = (grantValid && grantIdx == CH_W'(i)) ? cmdReg[CMD_ACKHIGH]
                                                             : ~cmdReg[CMD_ACKHIGH];
  end

endmodule

// File: rtl/dmaarb_checker.sv
module dmaarb_checker #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              seqIdle,
  input logic              seqRelease,
  input logic              masterClr,
  input logic              grantValid,
  input logic [CH_W-1:0]   grantIdx,
  input logic [NUM_CH-1:0] dackPin,
  input logic [7:0]        cmdReg,
  input logic [NUM_CH-1:0] maskReg
);

  p_hold_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !seqRelease && !masterClr) |=> (grantValid && $stable(grantIdx)));

  p_busy_no_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!seqIdle && !grantValid) |=> !grantValid);

  p_release_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && seqRelease && !masterClr) |=> !grantValid);

  p_off_no_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg[2] && !grantValid) |=> !grantValid);

  p_one_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(dackPin ^ {NUM_CH{~cmdReg[7]}}) == (grantValid ? 1 : 0));

  p_ack_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (dackPin[grantIdx] == cmdReg[7]));

  p_wipe_masks_r10: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |=> (&maskReg && !grantValid));

endmodule

bind dmaarb_top dmaarb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .seqIdle    (seqIdle),
  .seqRelease (seqRelease),
  .masterClr  (masterClr),
  .grantValid (grantValid),
  .grantIdx   (grantIdx),
  .dackPin    (dackPin),
  .cmdReg     (cmdReg),
  .maskReg    (maskReg)
);

// File: tb/dmaarb_top_test.sv
module dmaarb_top_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       cmdWr = 0, modeWr = 0, reqWr = 0, maskOneWr = 0, maskAllWr = 0;
  logic       maskClrWr = 0, masterClr = 0, statusRd = 0;
  logic [3:0] dreqPin = '0, tcEvt = '0, eopEvt = '0;
  logic       seqIdle = 1'b1, seqRelease = 1'b0;
  logic [1:0] grantIdx;
  logic       grantValid;
  logic [3:0] dackPin;
  logic [7:0] statusOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // {command, logical request pattern, expected channel or F for none}
  localparam logic [15:0] VEC [12] = '{
    16'h00F0, 16'h00C2, 16'h00A1, 16'h10F2, 16'h10F3, 16'h10F0,
    16'h1010, 16'h1093, 16'h04FF, 16'h4042, 16'h8021, 16'h5062
  };

  dmaarb_top uut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .cmdWr(cmdWr), .modeWr(modeWr),
    .reqWr(reqWr), .maskOneWr(maskOneWr), .maskAllWr(maskAllWr),
    .maskClrWr(maskClrWr), .masterClr(masterClr), .statusRd(statusRd),
    .dreqPin(dreqPin), .tcEvt(tcEvt), .eopEvt(eopEvt), .seqIdle(seqIdle),
    .seqRelease(seqRelease), .grantIdx(grantIdx), .grantValid(grantValid),
    .dackPin(dackPin), .statusOut(statusOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expGrant(input bit v, input logic [1:0] ch, input string tag);
    chk(grantValid == v, tag, grantValid, v);
    if (v) chk(grantIdx == ch, tag, grantIdx, ch);
  endtask

  task automatic release1();
    seqRelease = 1'b1; step(1); seqRelease = 1'b0;
  endtask

  task automatic strobe(input int which, input logic [7:0] d);
    wrData = d;
    case (which)
      0: cmdWr = 1;  1: modeWr = 1;  2: reqWr = 1;     3: maskOneWr = 1;
      4: maskAllWr = 1; 5: maskClrWr = 1; 6: masterClr = 1; default: statusRd = 1;
    endcase
    step(1);
    {cmdWr, modeWr, reqWr, maskOneWr, maskAllWr, maskClrWr, masterClr, statusRd} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    // reset state (R10)
    chk(grantValid == 0, "R10 reset grant", grantValid, 0);
    chk(statusOut == 8'h00, "R10 reset status", statusOut, 0);
    chk(dackPin == 4'hF, "R5 idle ack low-active", dackPin, 4'hF);
    // masks set after reset (R10, R6)
    dreqPin = 4'hF; step(3);
    chk(grantValid == 0, "R10 masks set at reset", grantValid, 0);
    strobe(5, 8'h00); step(1);
    expGrant(1, 0, "R6 clear-mask enables");
    dreqPin = 4'h0; release1(); step(1);

    // vector walk: R1, R2, R4, R5
    foreach (VEC[n]) begin
      logic [7:0] c;
      logic [3:0] pat, oh, ea;
      bit v;
      c = VEC[n][15:8]; pat = VEC[n][7:4];
      v = (VEC[n][3:0] != 4'hF);
      strobe(0, c);
      dreqPin = pat ^ {4{c[6]}};
      step(1);
      expGrant(v, VEC[n][1:0], c[2] ? "R4 disabled" : (c[4] ? "R2 rotating" : "R1 fixed"));
      oh = v ? (4'b0001 << VEC[n][1:0]) : 4'b0000;
      ea = c[7] ? oh : ~oh;
      chk(dackPin == ea, "R5 ack level", dackPin, ea);
      dreqPin = {4{c[6]}};
      release1();
      chk(grantValid == 0, "R3 release drops", grantValid, 0);
      step(1);
    end
    strobe(0, 8'h00); dreqPin = 4'h0; step(1);

    // grant hold and busy sequencer (R3)
    dreqPin = 4'h8; step(1);
    expGrant(1, 3, "R3 grant ch3");
    dreqPin = 4'h9; step(3);
    expGrant(1, 3, "R3 grant held");
    seqIdle = 0; release1(); step(3);
    expGrant(0, 0, "R3 busy no grant");
    seqIdle = 1; step(1);
    expGrant(1, 0, "R3 idle grant");
    dreqPin = 4'h0; release1(); step(1);

    // software request in block mode bypasses mask (R7)
    strobe(1, 8'h81);
    strobe(4, 8'h0F);
    seqIdle = 0;
    strobe(2, 8'h05);
    chk(statusOut == 8'h20, "R9 request status", statusOut, 8'h20);
    seqIdle = 1; step(1);
    expGrant(1, 1, "R7 soft request unmasked");
    // terminal count clears request, flags status (R8, R9)
    tcEvt = 4'h2; step(1); tcEvt = 4'h0;
    chk(statusOut == 8'h02, "R8 tc clears req and flags", statusOut, 8'h02);
    release1(); step(2);
    expGrant(0, 0, "R8 no regrant");
    strobe(7, 8'h00);
    chk(statusOut == 8'h00, "R9 read clears", statusOut, 0);
    // single-mode software request ignored (R7)
    strobe(1, 8'h42);
    strobe(2, 8'h06); step(2);
    expGrant(0, 0, "R7 non-block ignored");
    chk(statusOut == 8'h40, "R9 shows soft req", statusOut, 8'h40);
    strobe(2, 8'h02);
    chk(statusOut == 8'h00, "R7 clear soft req", statusOut, 0);

    // auto mask on end event without auto-init (R8)
    strobe(5, 8'h00);
    dreqPin = 4'h8; step(1);
    expGrant(1, 3, "R8 grant ch3");
    eopEvt = 4'h8; step(1); eopEvt = 4'h0;
    release1(); step(2);
    expGrant(0, 0, "R8 mask set at end");
    chk(statusOut == 8'h88, "R9 flag and pin", statusOut, 8'h88);
    dreqPin = 4'h0;
    // auto-init keeps mask clear (R8)
    strobe(1, 8'h10);
    dreqPin = 4'h1; step(1);
    expGrant(1, 0, "R8 grant ch0");
    eopEvt = 4'h1; step(1); eopEvt = 4'h0;
    release1(); step(1);
    expGrant(1, 0, "R8 auto-init regrant");
    dreqPin = 4'h0; release1(); step(1);
    // read with same-edge event (R9)
    tcEvt = 4'h4; strobe(7, 8'h00); tcEvt = 4'h0;
    chk(statusOut == 8'h04, "R9 event beats read", statusOut, 8'h04);

    // single-mask set and clear (R6)
    strobe(3, 8'h04);
    dreqPin = 4'h1; step(2);
    expGrant(0, 0, "R6 single mask set");
    strobe(3, 8'h00); step(1);
    expGrant(1, 0, "R6 single mask clear");

    // master clear (R10)
    strobe(0, 8'h90);
    strobe(6, 8'h00);
    chk(grantValid == 0, "R10 clear drops grant", grantValid, 0);
    chk(dackPin == 4'hF, "R10 ack polarity reset", dackPin, 4'hF);
    chk(statusOut == 8'h10, "R10 flags cleared", statusOut, 8'h10);
    step(2);
    expGrant(0, 0, "R10 masks set by clear");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule